// File: doc/BRIEF.md
# Eight-Channel Interrupt Request Controller

This block gathers eight peripheral and external interrupt request lines and turns them into one interrupt line to the processor. Each line has its own enable. A rising edge on an enabled line is held as a pending event. When nothing is being served and the unit is enabled, the lowest-numbered pending channel is taken into service. Its number can be read back, and the processor interrupt stays up until software acknowledges that channel.

Channel use is fixed by the surrounding system: channel 0 is the watchdog timeout and channel 1 is unused. Channels 2, 3, 4 and 5 carry pin-change, serial-port, SPI-done and two-wire-done events. Channels 6 and 7 come from external pins. Software can also raise a pending event on any channel by writing the channel number together with a trigger bit. It drives everything through one 32-bit word register that has a write strobe and read data.

Top module: `irq_chan_ctrl`

## Requirements
- R1: After synchronous reset, all enables, pending events and the served channel number are zero. `cpu_irq` is 0 and `reg_rdata` reads 0.
- R2: `reg_rdata` reads as follows, with every other bit 0:
  - bits 15:8: the channel enables, channel n at bit 8+n;
  - bit 4: the unit enable;
  - bits 2:0: the served channel number.
  
  Bit 3 and bits 19:16 always read 0. A write with `reg_we`=1 loads bits 15:8 and bit 4 from `reg_wdata` at the clock edge.
- R3: A 0-to-1 change on `req_in[n]`, seen at a clock edge while channel n is enabled, makes channel n pending. An edge on a disabled channel is dropped, and enabling the channel afterwards does not raise it. A line held high causes no further events.
- R4: The served number is latched in the cycle after a pending event is seen while the block is idle and the unit enable is 1, and the lowest-numbered pending channel is chosen. The number is held until that channel is acknowledged, and a new request on another channel does not replace it.
- R5: `cpu_irq` is 1 exactly while a channel is in service and the unit enable is 1. Clearing the unit enable drops `cpu_irq` at the next edge and keeps the served number.
- R6: A write with bit 3 set while a channel is in service does two things:
  - it clears that channel's pending event, unless a new event for the same channel arrives in the same cycle;
  - it holds `cpu_irq` at 0 for two cycles, after which the next pending channel is presented.
  
  Bit 3 written while nothing is in service has no effect.
- R7: A write with bit 19 set makes the channel numbered in bits 18:16 pending, whether or not that channel is enabled. With bit 19 clear, bits 18:16 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| req_in | input | 8 | Interrupt request lines, one per channel |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach is a new edge arriving on the served channel in the same cycle as its acknowledge, while other channels are also pending. After that cycle the channel must be pending again, and it must win again after the two-cycle gap. Random request toggling, with occasional writes that carry an acknowledge, random enables and injections, hits this overlap repeatedly. Directed sequences cover the following:
- priority among simultaneous edges;
- no preemption by a new request;
- dropped edges on a disabled channel;
- injection into a disabled channel;
- the unit enable masking an interrupt that is in service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    parameter int NUM_CH = 8;
    localparam int ID_W = $clog2(NUM_CH);

    // control word bit positions
    localparam int ID_LSB      = 0;
    localparam int ACK_BIT     = 3;
    localparam int GEN_BIT     = 4;
    localparam int EN_LSB      = 8;
    localparam int INJ_SEL_LSB = 16;
    localparam int INJ_GO_BIT  = 19;
    localparam int WORD_W      = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_GAP   = 2'd2
    } srv_state_t;

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic              gen;
        logic              ack;
        logic              inj_go;
        logic [ID_W-1:0]   inj_sel;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_word(input logic [WORD_W-1:0] w);
        ctrl_cmd_t c;
        c.en      = w[EN_LSB +: NUM_CH];
        c.gen     = w[GEN_BIT];
        c.ack     = w[ACK_BIT];
        c.inj_go  = w[INJ_GO_BIT];
        c.inj_sel = w[INJ_SEL_LSB +: ID_W];
        return c;
    endfunction

    function automatic logic [ID_W-1:0] lowest_set(input logic [NUM_CH-1:0] p);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (p[i]) r = ID_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int N = NUM_CH,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  en_i,
    input  logic          inj_go_i,
    input  logic [IW-1:0] inj_sel_i,
    input  logic          clr_go_i,
    input  logic [IW-1:0] clr_sel_i,
    output logic [N-1:0]  pend_o
);

    logic [N-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_i;
    end

    for (genvar n = 0; n < N; n++) begin : g_ch
        logic set_n, clr_n;
        assign set_n = (req_i[n] && !req_q[n] && en_i[n]) ||
                       (inj_go_i && (inj_sel_i == IW'(n)));
        assign clr_n = clr_go_i && (clr_sel_i == IW'(n));

        always_ff @(posedge clk) begin
            if (rst) pend_o[n] <= 1'b0;
            else     pend_o[n] <= (pend_o[n] && !clr_n) || set_n;
        end

        // R6
        pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $fell(pend_o[n])) |-> $past(clr_go_i && (clr_sel_i == IW'(n))));
    end

endmodule

// File: rtl/irqc_serve.sv
module irqc_serve
    import irqc_pkg::*;
#(
    parameter int N = NUM_CH,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gen_i,
    input  logic          any_i,
    input  logic [IW-1:0] pick_i,
    input  logic          ack_i,
    output logic [IW-1:0] id_o,
    output logic          irq_o,
    output logic          ack_take_o
);

    srv_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            id_o  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (gen_i && any_i) begin
                    state <= ST_SERVE;
                    id_o  <= pick_i;
                end
                ST_SERVE: if (ack_i) state <= ST_GAP;
                ST_GAP:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign ack_take_o = (state == ST_SERVE) && ack_i;
    assign irq_o      = (state == ST_SERVE) && gen_i;

    // R4
    id_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERVE && !ack_i) |=> $stable(id_o));

    // R6
    ack_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ack_take_o |=> (!irq_o ##1 !irq_o));

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int N = NUM_CH,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic          any_o,
    output logic [IW-1:0] pick_o
);

    assign any_o  = |pend_i;
    assign pick_o = lowest_set(pend_i);

endmodule

// File: rtl/irq_chan_ctrl.sv
module irq_chan_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] req_in,
    output logic              cpu_irq
);

    ctrl_cmd_t         cmd;
    logic [NUM_CH-1:0] en_q;
    logic              gen_q;
    logic [NUM_CH-1:0] pend;
    logic              any_p;
    logic [ID_W-1:0]   pick;
    logic [ID_W-1:0]   srv_id;
    logic              ack_take;

    assign cmd = decode_word(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            gen_q <= 1'b0;
        end else if (reg_we) begin
            en_q  <= cmd.en;
            gen_q <= cmd.gen;
        end
    end

    irqc_pending #(.N(NUM_CH)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_in),
        .en_i      (en_q),
        .inj_go_i  (reg_we && cmd.inj_go),
        .inj_sel_i (cmd.inj_sel),
        .clr_go_i  (ack_take),
        .clr_sel_i (srv_id),
        .pend_o    (pend)
    );

    irqc_pick #(.N(NUM_CH)) u_pick (
        .pend_i (pend),
        .any_o  (any_p),
        .pick_o (pick)
    );

    irqc_serve #(.N(NUM_CH)) u_serve (
        .clk        (clk),
        .rst        (rst),
        .gen_i      (gen_q),
        .any_i      (any_p),
        .pick_i     (pick),
        .ack_i      (reg_we && cmd.ack),
        .id_o       (srv_id),
        .irq_o      (cpu_irq),
        .ack_take_o (ack_take)
    );

    always_comb begin
        reg_rdata = '0;
        reg_rdata[EN_LSB +: NUM_CH] = en_q;
        reg_rdata[GEN_BIT]          = gen_q;
        reg_rdata[ID_LSB +: ID_W]   = srv_id;
    end

    // R5
    irq_gen_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> gen_q);

    // R4
    irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> pend[srv_id]);

endmodule

// File: tb/irq_chan_ctrl_test.sv
module irq_chan_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  req_in = '0;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_chan_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_in(req_in), .cpu_irq(cpu_irq)
    );

    // requirement-level reference state
    logic [7:0] m_en, m_pend, m_prev;
    logic       m_gen;
    int         m_st;     // 0 idle, 1 serving, 2 gap
    logic [2:0] m_id;

    function automatic logic [2:0] first_one(input logic [7:0] p);
        for (int i = 0; i < 8; i++) if (p[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] en, input logic g,
                                             input logic [2:0] id);
        return {16'h0, en, 3'b000, g, 1'b0, id};
    endfunction

    always @(posedge clk) begin
        logic [7:0] set_v, clr_v;
        if (rst) begin
            m_en = '0; m_pend = '0; m_prev = '0; m_gen = 0; m_st = 0; m_id = '0;
        end else begin
            set_v = req_in & ~m_prev & m_en;
            if (reg_we && reg_wdata[19]) set_v[reg_wdata[18:16]] = 1'b1;
            clr_v = '0;
            if (m_st == 1 && reg_we && reg_wdata[3]) clr_v[m_id] = 1'b1;
            case (m_st)
                0: if (m_gen && m_pend != 0) begin m_st = 1; m_id = first_one(m_pend); end
                1: if (reg_we && reg_wdata[3]) m_st = 2;
                default: m_st = 0;
            endcase
            m_pend = (m_pend & ~clr_v) | set_v;
            if (reg_we) begin m_en = reg_wdata[15:8]; m_gen = reg_wdata[4]; end
            m_prev = req_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            check("R2/R4 rdata vs model", reg_rdata, exp_word(m_en, m_gen, m_id));
            check("R5/R6 irq vs model", {31'h0, cpu_irq}, {31'h0, (m_st == 1) && m_gen});
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        model_on = 1'b1;
        // R1
        check("R1 reset rdata", reg_rdata, 32'h0);
        check("R1 reset irq", {31'h0, cpu_irq}, 32'h0);
        // R2
        wr(32'h0000_FF10);
        check("R2 readback", reg_rdata, 32'h0000_FF10);
        // R4 lowest of simultaneous edges
        req_in = 8'hA0;
        tick(); tick();
        check("R4 pick ch5", reg_rdata, 32'h0000_FF15);
        check("R5 irq raised", {31'h0, cpu_irq}, 32'h1);
        // R4 no preemption
        req_in = 8'hA4;
        tick(); tick();
        check("R4 held id", reg_rdata[2:0], 32'h5);
        // R6 ack gap then next
        wr(32'h0000_FF18);
        check("R6 gap1", {31'h0, cpu_irq}, 32'h0);
        tick();
        check("R6 gap2", {31'h0, cpu_irq}, 32'h0);
        tick();
        check("R6 next ch2", reg_rdata, 32'h0000_FF12);
        wr(32'h0000_FF18); tick(); tick();
        check("R6 next ch7", reg_rdata, 32'h0000_FF17);
        wr(32'h0000_FF18); tick(); tick();
        // R3 held lines do not retrigger
        check("R3 no retrigger", {31'h0, cpu_irq}, 32'h0);
        // R6 ack while idle ignored
        wr(32'h0000_FF18); tick();
        check("R6 idle ack", {31'h0, cpu_irq}, 32'h0);
        // R3 disabled edge dropped
        req_in = 8'h00;
        wr(32'h0000_0010);
        req_in = 8'h02; tick();
        wr(32'h0000_0210); tick(); tick();
        check("R3 dropped edge", {31'h0, cpu_irq}, 32'h0);
        // R7 bit19 clear: no injection
        wr(32'h0001_0210); tick(); tick();
        check("R7 no go", {31'h0, cpu_irq}, 32'h0);
        // R7 inject disabled ch6
        wr(32'h000E_0210); tick();
        check("R7 inject ch6", reg_rdata, 32'h0000_0216);
        check("R7 inject irq", {31'h0, cpu_irq}, 32'h1);
        // R5 unit enable off masks irq, id kept
        wr(32'h0000_0200);
        check("R5 masked", {31'h0, cpu_irq}, 32'h0);
        check("R5 id kept", reg_rdata, 32'h0000_0206);
        wr(32'h0000_0218); tick(); tick();
        // random phase
        for (int c = 0; c < 6000; c++) begin
            if (($urandom % 3) == 0) req_in = req_in ^ 8'(1 << ($urandom % 8));
            if (($urandom % 6) == 0) begin
                reg_we = 1'b1;
                reg_wdata = {12'h0, ($urandom % 4) == 0, 3'($urandom),
                             8'($urandom | 8'h0F), 3'b000, ($urandom % 8) != 0,
                             ($urandom % 2) == 0, 3'($urandom)};
            end else begin
                reg_we = 1'b0; reg_wdata = '0;
            end
            tick();
        end
        reg_we = 1'b0;
        tick();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule